// File: doc/BRIEF.md
# Auto-Incrementing Multiplexer Channel Sequencer

This block produces the channel address for the analog multiplexer of a data acquisition front end. Software writes a start channel. A set of eight binary-weighted switches gives the highest channel of the scan. On every accepted conversion strobe the sequencer does one of three things: it loads the start channel, moves up by one, or returns to the start channel once the limit has been reached. The current channel can be read back at any time. The low four address bits drive an on-board sixteen-way multiplexer. The upper bits of the channel and of the limit are carried to an expansion connector.

A strobe can come from three places: a software pulse, an external trigger level whose rising edge counts only while software has enabled it, or a second external pin that always reacts to a falling edge. A completion pulse from the converter ends the busy period. A strobe that arrives while a conversion is still running is refused and reported as an overrun.

Top module: `chan_seq_top`

## Requirements
- R1: After reset the channel is 0, the start channel is 0, the next accepted strobe loads the start channel, busy, conversion-start and overrun are 0, and the external trigger is masked.
- R2: The first accepted strobe after a start-channel write (or after reset) sets the channel to the start channel. The new channel, `conv_start`=1 and `busy`=1 appear in the cycle after the strobe.
- R3: An accepted strobe with no load pending and a channel below `max_chan` increments the channel by one.
- R4: An accepted strobe with no load pending and a channel greater than or equal to `max_chan` sets the channel back to the start channel. This holds even when the start channel is above the limit, and the channel never counts past the limit.
- R5: A strobe while busy leaves the channel unchanged, gives no `conv_start`, and gives a one-cycle `overrun` pulse in the next cycle.
- R6: `busy` is set by an accepted strobe and cleared by `conv_done`. A strobe that falls in the same cycle as `conv_done` is accepted.
- R7: A rising edge on `ext_trig` acts as a strobe only while the trigger enable (written through `trig_en_wr`/`trig_en_wdata`, 1 = enabled) is set.
- R8: A falling edge on `ext_strobe_n` acts as a strobe whatever the trigger enable is.
- R9: `chan_out` is bits [3:0] of the channel, with bit 3 forced to 0 when `diff_mode`=1. `exp_addr` is channel bits [7:4] and `exp_limit` is `max_chan` bits [7:4].
- R10: Several strobe sources that fire in one cycle count as a single strobe.
- R11: A start-channel write in the same cycle as an accepted strobe makes that strobe load the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Write strobe for the start-channel register |
| addr_wdata | input | 8 | Start channel value |
| trig_en_wr | input | 1 | Write strobe for the trigger enable |
| trig_en_wdata | input | 1 | Trigger enable value, 1 = enabled |
| sw_strobe | input | 1 | Software conversion strobe pulse |
| ext_trig | input | 1 | Gated external trigger, acts on its rising edge |
| ext_strobe_n | input | 1 | Ungated external strobe, acts on its falling edge |
| conv_done | input | 1 | Conversion-complete pulse |
| max_chan | input | 8 | Switch-set last channel of the scan |
| diff_mode | input | 1 | Differential input mode, 8 channel pairs |
| chan_q | output | 8 | Current channel, for status readback |
| chan_out | output | 4 | Address to the on-board multiplexer |
| exp_addr | output | 4 | Upper channel bits to the expansion port |
| exp_limit | output | 4 | Upper limit bits to the expansion port |
| busy | output | 1 | A conversion is in progress |
| conv_start | output | 1 | One-cycle pulse that starts a conversion |
| overrun | output | 1 | One-cycle pulse for a refused strobe |

## Verification
The most delicate collision is a new strobe that lands in the same cycle as `conv_done`. The sequencer must accept it and advance, not raise an overrun. The bench provokes this by holding the first conversion open, then driving the strobe and the completion pulse together. It judges the result on the channel, `conv_start`, `busy` and `overrun` one cycle later. A second collision, a start-channel write together with a strobe, is driven the same way, and the bench expects the freshly written channel.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;

    typedef struct packed {
        logic trig_prev;
        logic strb_n_prev;
        logic trig_en;
    } src_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP,
        ACT_WRAP
    } seq_act_e;

endpackage

// File: rtl/chan_strobe_src.sv
module chan_strobe_src
    import chan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_strobe,
    input  logic ext_trig,
    input  logic ext_strobe_n,
    input  logic en_wr,
    input  logic en_wdata,
    output logic strobe
);

    src_state_t s_d, s_q;
    logic       trig_hit;
    logic       pin_hit;

    always_comb begin
        s_d             = s_q;
        s_d.trig_prev   = ext_trig;
        s_d.strb_n_prev = ext_strobe_n;
        if (en_wr) begin
            s_d.trig_en = en_wdata;
        end
        trig_hit = s_q.trig_en & ext_trig & ~s_q.trig_prev;
        pin_hit  = ~ext_strobe_n & s_q.strb_n_prev;
        strobe   = sw_strobe | trig_hit | pin_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{trig_prev: 1'b0, strb_n_prev: 1'b1, trig_en: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    // R7: with the trigger masked and the other sources quiet, no strobe
    a_r7_masked_trig: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.trig_en && !sw_strobe && ext_strobe_n) |-> !strobe);

    // R8: a falling edge on the ungated pin always gives a strobe
    a_r8_ungated_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_strobe_n) |-> strobe);

endmodule

// File: rtl/chan_seq_core.sv
module chan_seq_core
    import chan_seq_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              conv_done,
    input  logic              addr_wr,
    input  logic [CHAN_W-1:0] addr_wdata,
    input  logic [CHAN_W-1:0] max_chan,
    output logic [CHAN_W-1:0] chan,
    output logic              busy,
    output logic              conv_start,
    output logic              overrun
);

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [CHAN_W-1:0] start;
        logic              pend;
        logic              busy;
        logic              cs;
        logic              ov;
    } core_state_t;

    core_state_t       st_d, st_q;
    seq_act_e          act;
    logic              take;
    logic              eff_pend;
    logic [CHAN_W-1:0] eff_start;

    always_comb begin
        st_d      = st_q;
        act       = ACT_HOLD;
        eff_start = addr_wr ? addr_wdata : st_q.start;
        eff_pend  = addr_wr | st_q.pend;
        take      = strobe & (~st_q.busy | conv_done);

        if (take) begin
            if (eff_pend) begin
                act = ACT_LOAD;
            end else if (st_q.chan >= max_chan) begin
                act = ACT_WRAP;
            end else begin
                act = ACT_STEP;
            end
        end

        st_d.start = eff_start;
        st_d.pend  = eff_pend & ~take;
        case (act)
            ACT_LOAD, ACT_WRAP: st_d.chan = eff_start;
            ACT_STEP:           st_d.chan = st_q.chan + 1'b1;
            default:            st_d.chan = st_q.chan;
        endcase
        st_d.busy = take | (st_q.busy & ~conv_done);
        st_d.cs   = take;
        st_d.ov   = strobe & ~take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{chan: '0, start: '0, pend: 1'b1, busy: 1'b0, cs: 1'b0, ov: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign chan       = st_q.chan;
    assign busy       = st_q.busy;
    assign conv_start = st_q.cs;
    assign overrun    = st_q.ov;

    // R5: a refused strobe keeps the channel
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && strobe && !conv_done) |=> $stable(chan));

    // R5: a refused strobe reports an overrun
    a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && strobe && !conv_done) |=> (overrun && !conv_start));

    // R6: a conversion start always leaves the block busy
    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> busy);

    // R3: a plain step moves up by exactly one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !st_q.busy && !st_q.pend && !addr_wr && st_q.chan < max_chan)
        |=> chan == $past(st_q.chan) + 1'b1);

    // R4: at or past the limit the channel returns to the start
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !st_q.busy && !st_q.pend && !addr_wr && st_q.chan >= max_chan)
        |=> chan == $past(st_q.start));

    // R1: start and overrun pulses never coincide
    a_r1_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({conv_start, overrun}));

endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top #(
    parameter int CHAN_W = 8,
    parameter int MUX_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                addr_wr,
    input  logic [CHAN_W-1:0]   addr_wdata,
    input  logic                trig_en_wr,
    input  logic                trig_en_wdata,
    input  logic                sw_strobe,
    input  logic                ext_trig,
    input  logic                ext_strobe_n,
    input  logic                conv_done,
    input  logic [CHAN_W-1:0]   max_chan,
    input  logic                diff_mode,
    output logic [CHAN_W-1:0]   chan_q,
    output logic [MUX_W-1:0]    chan_out,
    output logic [CHAN_W-MUX_W-1:0] exp_addr,
    output logic [CHAN_W-MUX_W-1:0] exp_limit,
    output logic                busy,
    output logic                conv_start,
    output logic                overrun
);

    localparam int PAIR_W = MUX_W - 1;

    logic strobe;

    chan_strobe_src u_src (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_strobe    (sw_strobe),
        .ext_trig     (ext_trig),
        .ext_strobe_n (ext_strobe_n),
        .en_wr        (trig_en_wr),
        .en_wdata     (trig_en_wdata),
        .strobe       (strobe)
    );

    chan_seq_core #(.CHAN_W(CHAN_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .conv_done  (conv_done),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .max_chan   (max_chan),
        .chan       (chan_q),
        .busy       (busy),
        .conv_start (conv_start),
        .overrun    (overrun)
    );

    // Differential pairs share the lower half of the mux: top address bit is dropped
    always_comb begin
        chan_out = chan_q[MUX_W-1:0];
        if (diff_mode) begin
            chan_out = {1'b0, chan_q[PAIR_W-1:0]};
        end
    end

    assign exp_addr  = chan_q[CHAN_W-1:MUX_W];
    assign exp_limit = max_chan[CHAN_W-1:MUX_W];

endmodule

// File: tb/chan_seq_top_bench.sv
module chan_seq_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr = 1'b0;
    logic [7:0] addr_wdata = '0;
    logic       trig_en_wr = 1'b0;
    logic       trig_en_wdata = 1'b0;
    logic       sw_strobe = 1'b0;
    logic       ext_trig = 1'b0;
    logic       ext_strobe_n = 1'b1;
    logic       conv_done = 1'b0;
    logic [7:0] max_chan = 8'd5;
    logic       diff_mode = 1'b0;
    logic [7:0] chan_q;
    logic [3:0] chan_out;
    logic [3:0] exp_addr;
    logic [3:0] exp_limit;
    logic       busy;
    logic       conv_start;
    logic       overrun;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chan_seq_top u_chan_seq_top (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .trig_en_wr(trig_en_wr), .trig_en_wdata(trig_en_wdata),
        .sw_strobe(sw_strobe), .ext_trig(ext_trig), .ext_strobe_n(ext_strobe_n),
        .conv_done(conv_done), .max_chan(max_chan), .diff_mode(diff_mode),
        .chan_q(chan_q), .chan_out(chan_out), .exp_addr(exp_addr),
        .exp_limit(exp_limit), .busy(busy), .conv_start(conv_start),
        .overrun(overrun)
    );

    // behavioural reference state
    int m_chan, m_start, m_pend, m_busy, m_en, m_tprev, m_nprev, m_cs, m_ov;

    task automatic model_reset();
        m_chan = 0; m_start = 0; m_pend = 1; m_busy = 0; m_en = 0;
        m_tprev = 0; m_nprev = 1; m_cs = 0; m_ov = 0;
    endtask

    task automatic model_clock();
        int stb, ok;
        stb = sw_strobe || (m_en && ext_trig && !m_tprev) || (!ext_strobe_n && m_nprev);
        if (addr_wr) begin m_start = addr_wdata; m_pend = 1; end
        ok = stb && (!m_busy || conv_done);
        if (ok) begin
            if (m_pend) begin m_chan = m_start; m_pend = 0; end
            else if (m_chan >= max_chan) m_chan = m_start;
            else m_chan = m_chan + 1;
        end
        if (ok) m_busy = 1; else if (conv_done) m_busy = 0;
        m_cs = ok;
        m_ov = stb && !ok;
        if (trig_en_wr) m_en = trig_en_wdata;
        m_tprev = ext_trig;
        m_nprev = ext_strobe_n;
    endtask

    task automatic chk(string tag, string name, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s got %0h exp %0h", tag, name, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int eo;
        eo = diff_mode ? (m_chan & 7) : (m_chan & 15);
        chk(tag, "chan_q", chan_q, m_chan);
        chk(tag, "chan_out", chan_out, eo);
        chk(tag, "exp_addr", exp_addr, m_chan >> 4);
        chk(tag, "exp_limit", exp_limit, max_chan >> 4);
        chk(tag, "busy", busy, m_busy);
        chk(tag, "conv_start", conv_start, m_cs);
        chk(tag, "overrun", overrun, m_ov);
    endtask

    // one clock: model follows the driven inputs, outputs compared after the edge
    task automatic step(string tag);
        @(posedge clk);
        if (rst_n) model_clock(); else model_reset();
        #2;
        compare(tag);
        addr_wr = 0; trig_en_wr = 0; sw_strobe = 0; conv_done = 0;
    endtask

    task automatic conv(string tag);
        sw_strobe = 1; step(tag);
        conv_done = 1; step(tag);
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");

        // R2: load written start, then R3 steps and R4 wrap with limit 5
        addr_wr = 1; addr_wdata = 8'd2; step("R2");
        conv("R2");
        conv("R3"); conv("R3"); conv("R3");
        conv("R4"); conv("R3");

        // R4: start above the limit keeps returning to the start
        addr_wr = 1; addr_wdata = 8'd9; step("R2");
        conv("R2"); conv("R4"); conv("R4");

        // R5: strobe while busy
        sw_strobe = 1; step("R5");
        sw_strobe = 1; step("R5");
        step("R5");
        conv_done = 1; step("R6");

        // R6: strobe in the same cycle as completion is accepted
        sw_strobe = 1; step("R6");
        sw_strobe = 1; conv_done = 1; step("R6");
        conv_done = 1; step("R6");

        // R7: masked trigger, then enabled trigger
        ext_trig = 1; step("R7");
        ext_trig = 0; step("R7");
        trig_en_wr = 1; trig_en_wdata = 1; step("R7");
        ext_trig = 1; step("R7");
        ext_trig = 0; conv_done = 1; step("R7");

        // R8: ungated pin with trigger masked
        trig_en_wr = 1; trig_en_wdata = 0; step("R8");
        ext_strobe_n = 0; step("R8");
        ext_strobe_n = 1; conv_done = 1; step("R8");

        // R10: software and pin strobe together give one advance
        sw_strobe = 1; ext_strobe_n = 0; step("R10");
        ext_strobe_n = 1; conv_done = 1; step("R10");

        // R11: write and strobe in one cycle
        addr_wr = 1; addr_wdata = 8'd4; sw_strobe = 1; step("R11");
        conv_done = 1; step("R11");

        // R9: differential mask and expansion bits
        max_chan = 8'hA5;
        addr_wr = 1; addr_wdata = 8'd12; step("R9");
        conv("R9");
        diff_mode = 1; step("R9");
        addr_wr = 1; addr_wdata = 8'h9D; step("R9");
        conv("R9");
        diff_mode = 0; step("R9");

        // R4: wrap at the top of the range
        max_chan = 8'hFF;
        addr_wr = 1; addr_wdata = 8'hFE; step("R4");
        conv("R4"); conv("R4"); conv("R4"); conv("R4");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule